// File: doc/BRIEF.md
# Wake-up External Interrupt Controller

This block watches 28 asynchronous wake-up input lines and turns activity on them into four interrupt requests. Each line is first brought into the clock domain by a two-stage synchroniser. A trigger mode chosen per pair of adjacent lines then looks for a low level, a high level, a falling edge, a rising edge or either edge. When that condition is met it sets a sticky pending bit for the line. A per-line mask bit decides whether a pending line may reach its output.

Software programs the block through a simple word-wide register bus with a 4-bit byte address, a write strobe and write data. Read data is returned combinationally for whatever address is presented. The lines are grouped onto four outputs of uneven width: the first covers 4 lines and the other three cover 8 lines each. An interrupt handler can therefore tell from the output which range of lines to scan in the pending word. A handler clears a pending bit by writing a one to it.

Top module: `wake_irq_ctrl`

## Requirements
- R1: While the reset input is low and on the first cycle after it, every mask bit is 1 (the mask word reads 0x0FFFFFFF), every trigger field is 0, nothing is pending and all four outputs are 0.
- R2: Register map by byte address. 0x0 is trigger word A (32 bits). 0x4 is trigger word B, whose bits 23:0 are stored and whose bits 31:24 read 0. 0x8 is the mask word (bits 27:0). 0xC is the pending word (bits 27:0). Any other address reads 0 and a write to it changes nothing; unused bits read 0.
- R3: Line n is governed by the 4-bit field at bit 4*((n mod 16)/2) of word A for n below 16, and of word B otherwise. Lines 2k and 2k+1 share one field.
- R4: Field code 0 sets the pending bit on every cycle the synchronised line is 0, and code 1 on every cycle it is 1. A clear written while the level persists is overridden at once.
- R5: Code 2 sets the pending bit on a 1-to-0 transition of the synchronised line, code 4 on a 0-to-1 transition, and code 6 on either.
- R6: An input change presented before clock edge k sets the pending bit at edge k+2, for edge modes and level modes alike.
- R7: A write to 0xC clears each pending bit written with 1 and leaves bits written with 0 unchanged. A detection in the same cycle as the clear wins, and the bit stays set.
- R8: A mask bit of 1 keeps its line off the outputs but does not stop the pending bit from being set. Clearing the mask bit exposes a bit that is already pending on the next cycle.
- R9: Output 0 is the OR of unmasked pending lines 0-3, output 1 of lines 4-11, output 2 of lines 12-19 and output 3 of lines 20-27.
- R10: Codes outside the five named ones decode bitwise. If bit 1 or bit 2 is set, the field is an edge mode, with bit 1 selecting falling and bit 2 selecting rising. Otherwise bit 0 chooses high level (1) or low level (0). Bit 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 28 | Asynchronous wake-up input lines |
| busAddr | input | 4 | Byte address of the register accessed |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 4 | Range interrupt requests |

## Verification
Two functions can land on the same clock edge: a software clear of a pending bit and a fresh detection on the same line. The bench provokes this by raising a line in rising-edge mode and issuing the clear write exactly two edges later, so that the write and the detection share edge k+2. It also clears repeatedly while a level-high line is held. The cycle-accurate reference model in the bench applies set-over-clear priority, and the pending word and outputs are compared against it on every cycle, so any ordering other than "detection wins" shows up as a miscompare. A long stretch of random line activity and register writes then creates further collisions between clears, mask changes and detections.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;

  // Byte addresses of the register words
  localparam logic [3:0] ADDR_CFG_A = 4'h0;
  localparam logic [3:0] ADDR_CFG_B = 4'h4;
  localparam logic [3:0] ADDR_MASK  = 4'h8;
  localparam logic [3:0] ADDR_PEND  = 4'hC;

  // Named trigger codes of a 4-bit field
  typedef enum logic [3:0] {
    TRIG_LOW  = 4'd0,
    TRIG_HIGH = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_RISE = 4'd4,
    TRIG_BOTH = 4'd6
  } trig_e;

  // Strobes from the bus decoder to the datapath
  typedef struct packed {
    logic cfgAWr;
    logic cfgBWr;
    logic maskWr;
    logic pendClr;
  } strobe_t;

endpackage

// File: rtl/wake_irq_decode.sv
module wake_irq_decode
  import wake_irq_pkg::*;
#(
  parameter int NUM_LINES = 28,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWrEn,
  input  logic [NUM_LINES*2-1:0] cfgFlat,
  input  logic [NUM_LINES-1:0]   maskVec,
  input  logic [NUM_LINES-1:0]   pendVec,
  output strobe_t                strb,
  output logic [DATA_W-1:0]      busRdData
);
  localparam int FIELD_BITS = NUM_LINES * 2;
  localparam int HI_BITS    = FIELD_BITS - DATA_W;

  always_comb begin
    strb.cfgAWr  = busWrEn && (busAddr == ADDR_CFG_A);
    strb.cfgBWr  = busWrEn && (busAddr == ADDR_CFG_B);
    strb.maskWr  = busWrEn && (busAddr == ADDR_MASK);
    strb.pendClr = busWrEn && (busAddr == ADDR_PEND);
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CFG_A: busRdData = cfgFlat[DATA_W-1:0];
      ADDR_CFG_B: busRdData[HI_BITS-1:0] = cfgFlat[FIELD_BITS-1:DATA_W];
      ADDR_MASK:  busRdData[NUM_LINES-1:0] = maskVec;
      ADDR_PEND:  busRdData[NUM_LINES-1:0] = pendVec;
      default:    busRdData = '0;
    endcase
  end

endmodule

// File: rtl/wake_irq_core.sv
module wake_irq_core
  import wake_irq_pkg::*;
#(
  parameter int NUM_LINES   = 28,
  parameter int NUM_OUTS    = 4,
  parameter int DATA_W      = 32,
  parameter int FIRST_SPAN  = 4,
  parameter int SPAN        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_LINES-1:0]   lineIn,
  input  strobe_t                strb,
  input  logic [DATA_W-1:0]      wrData,
  output logic [NUM_LINES*2-1:0] cfgFlat,
  output logic [NUM_LINES-1:0]   maskVec,
  output logic [NUM_LINES-1:0]   pendVec,
  output logic [NUM_OUTS-1:0]    irqOut
);
  localparam int FIELD_BITS = NUM_LINES * 2;
  localparam int HI_BITS    = FIELD_BITS - DATA_W;

  // Lines belonging to output k
  function automatic logic [NUM_LINES-1:0] rangeOf(input int k);
    int lo;
    int hi;
    logic [NUM_LINES-1:0] r;
    lo = (k == 0) ? 0 : FIRST_SPAN + (k - 1) * SPAN;
    hi = FIRST_SPAN + k * SPAN - 1;
    r = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (n >= lo && n <= hi) r[n] = 1'b1;
    end
    return r;
  endfunction

  // Configuration and mask storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgFlat <= '0;
      maskVec <= '1;
    end else begin
      if (strb.cfgAWr) cfgFlat[DATA_W-1:0] <= wrData;
      if (strb.cfgBWr) cfgFlat[FIELD_BITS-1:DATA_W] <= wrData[HI_BITS-1:0];
      if (strb.maskWr) maskVec <= wrData[NUM_LINES-1:0];
    end
  end

  // Synchroniser chain plus one history stage for edge detection
  logic [NUM_LINES-1:0] syncQ [SYNC_STAGES];
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] curV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= lineIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign curV = syncQ[SYNC_STAGES-1];

  // Per-line trigger decode; a pair of lines shares one field
  logic [NUM_LINES-1:0] hitVec;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [3:0] code;
    logic       edgeMode;
    logic       riseHit;
    logic       fallHit;
    assign code     = cfgFlat[4*(n/2) +: 4];
    assign edgeMode = code[1] | code[2];
    assign riseHit  = code[2] & curV[n] & ~prevQ[n];
    assign fallHit  = code[1] & ~curV[n] & prevQ[n];
    assign hitVec[n] = edgeMode ? (riseHit | fallHit)
                                : (code[0] ? curV[n] : ~curV[n]);
  end

  // Pending capture: detection wins over a same-cycle clear
  logic [NUM_LINES-1:0] clrVec;
  assign clrVec = strb.pendClr ? wrData[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendVec <= '0;
    else       pendVec <= (pendVec & ~clrVec) | hitVec;
  end

  // Range OR onto the outputs
  logic [NUM_LINES-1:0] liveVec;
  assign liveVec = pendVec & ~maskVec;

  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
    localparam logic [NUM_LINES-1:0] RANGE = rangeOf(k);
    assign irqOut[k] = |(liveVec & RANGE);
  end

endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
  import wake_irq_pkg::*;
#(
  parameter int NUM_LINES = 28,
  parameter int NUM_OUTS  = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  output logic [NUM_OUTS-1:0]  irqOut
);
  strobe_t                strb;
  logic [NUM_LINES*2-1:0] cfgFlat;
  logic [NUM_LINES-1:0]   maskVec;
  logic [NUM_LINES-1:0]   pendVec;

  wake_irq_decode #(
    .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .busAddr(busAddr), .busWrEn(busWrEn), .cfgFlat(cfgFlat),
    .maskVec(maskVec), .pendVec(pendVec), .strb(strb),
    .busRdData(busRdData)
  );

  wake_irq_core #(
    .NUM_LINES(NUM_LINES), .NUM_OUTS(NUM_OUTS), .DATA_W(DATA_W)
  ) u_core (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strb(strb),
    .wrData(busWrData), .cfgFlat(cfgFlat), .maskVec(maskVec),
    .pendVec(pendVec), .irqOut(irqOut)
  );

endmodule

// File: rtl/wake_irq_chk.sv
module wake_irq_chk #(
  parameter int NUM_LINES = 28,
  parameter int NUM_OUTS  = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [DATA_W-1:0]    busWrData,
  input logic [DATA_W-1:0]    busRdData,
  input logic [NUM_OUTS-1:0]  irqOut,
  input logic [NUM_LINES-1:0] pendVec,
  input logic [NUM_LINES-1:0] maskVec
);
  // R1
  always @(negedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (irqOut == '0 && pendVec == '0 && maskVec == '1);
    end
  end

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 4'h8) |=> (maskVec == $past(busWrData[NUM_LINES-1:0])));

  // R2
  cfgb_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 4'h4) |-> (busRdData[DATA_W-1:NUM_LINES*2-DATA_W] == '0));

  // R8
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> ((pendVec & ~maskVec) != '0));

  // R7
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_hold
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pendVec[n] && !(busWrEn && busAddr == 4'hC && busWrData[n])) |=> pendVec[n]);
  end

endmodule

bind wake_irq_ctrl wake_irq_chk #(
  .NUM_LINES(NUM_LINES), .NUM_OUTS(NUM_OUTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut),
  .pendVec(pendVec), .maskVec(maskVec)
);

// File: tb/tb_wake_irq_ctrl.sv
`timescale 1ns/1ps
module tb_wake_irq_ctrl;
  import wake_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [27:0] lineIn = '0;
  logic [3:0]  busAddr = 4'hC;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  irqOut;

  wake_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  // Behavioural reference state
  logic [27:0] mS1, mS2, mPv, mPend, mMask;
  logic [55:0] mCfg;

  function automatic logic modelHit(input logic [3:0] c, input logic cur, input logic prv);
    if (c[1] || c[2]) return (c[2] && cur && !prv) || (c[1] && !cur && prv);
    return c[0] ? cur : !cur;
  endfunction

  function automatic logic [31:0] expRead(input logic [3:0] a);
    case (a)
      4'h0: return mCfg[31:0];
      4'h4: return {8'h00, mCfg[55:32]};
      4'h8: return {4'h0, mMask};
      4'hC: return {4'h0, mPend};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] expIrq();
    logic [27:0] live;
    live = mPend & ~mMask;
    return {|(live & 28'hFF00000), |(live & 28'h00FF000),
            |(live & 28'h0000FF0), |(live & 28'h000000F)};
  endfunction

  task automatic step();
    logic [27:0] hit;
    logic [27:0] clr;
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPv = '0; mPend = '0; mMask = '1; mCfg = '0;
    end else begin
      for (int n = 0; n < 28; n++) hit[n] = modelHit(mCfg[4*(n/2) +: 4], mS2[n], mPv[n]);
      clr = (busWrEn && busAddr == 4'hC) ? busWrData[27:0] : '0;
      if (busWrEn && busAddr == 4'h0) mCfg[31:0] = busWrData;
      if (busWrEn && busAddr == 4'h4) mCfg[55:32] = busWrData[23:0];
      if (busWrEn && busAddr == 4'h8) mMask = busWrData[27:0];
      mPend = (mPend & ~clr) | hit;
      mPv = mS2; mS2 = mS1; mS1 = lineIn;
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (irqOut !== expIrq()) begin
      miscompares++;
      $display("FAIL %s irqOut got %h expected %h at %0t", tag, irqOut, expIrq(), $time);
    end
    if (busRdData !== expRead(busAddr)) begin
      miscompares++;
      $display("FAIL %s read @%h got %h expected %h at %0t", tag, busAddr, busRdData,
               expRead(busAddr), $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    step();
    busWrEn = 1'b0; busAddr = 4'hC;
  endtask

  task automatic pulse(input int n, input int hold);
    lineIn[n] = 1'b1; idle(hold);
    lineIn[n] = 1'b0; idle(4);
  endtask

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    // R1: reset values of mask, fields, pending and outputs
    tag = "R1"; busAddr = 4'h8;
    idle(3);
    rstN = 1'b1;
    idle(1);
    busAddr = 4'hC; idle(2);

    // R2: register map, unused bits and addresses
    tag = "R2";
    wr(4'h0, 32'h1234_5678); busAddr = 4'h0; idle(1);
    wr(4'h4, 32'hFFFF_FFFF); busAddr = 4'h4; idle(1);
    wr(4'h2, 32'hDEAD_BEEF); busAddr = 4'h2; idle(1);
    busAddr = 4'h0; idle(1);
    busAddr = 4'h8; idle(1);

    // R9: each output range boundary under rising-edge mode
    tag = "R9";
    wr(4'h0, {8{TRIG_RISE}}); wr(4'h4, {8{TRIG_RISE}});
    wr(4'hC, 32'h0FFF_FFFF); wr(4'h8, 32'h0);
    idle(3);
    foreach (lineIn[i]) if (i inside {0, 3, 4, 11, 12, 19, 20, 27}) begin
      pulse(i, 3);
      wr(4'hC, 32'h1 << i);
      idle(1);
    end

    // R6: latency of two synchroniser stages
    tag = "R6";
    lineIn[6] = 1'b1; idle(1);
    lineIn[6] = 1'b0; idle(4);
    wr(4'hC, 32'h40);

    // R3: one field drives a pair, neighbours stay in their own modes
    tag = "R3";
    wr(4'h0, 32'h0000_0040); wr(4'h4, 32'h0000_0200);
    wr(4'h8, 32'h0FFC_FFF3);
    wr(4'hC, 32'h0FFF_FFFF);
    pulse(2, 3); pulse(3, 3); pulse(16, 3); pulse(17, 3);
    wr(4'hC, 32'h0FFF_FFFF); idle(2);

    // R5: falling, rising and both-edge modes
    tag = "R5";
    wr(4'h8, 32'h0); wr(4'h0, {8{TRIG_BOTH}}); wr(4'h4, {8{TRIG_BOTH}});
    wr(4'hC, 32'h0FFF_FFFF); idle(2);
    pulse(8, 5); wr(4'hC, 32'h0FFF_FFFF); idle(2);
    wr(4'h0, {8{TRIG_FALL}}); wr(4'h4, {8{TRIG_FALL}});
    lineIn[22] = 1'b1; idle(4); wr(4'hC, 32'h0FFF_FFFF);
    lineIn[22] = 1'b0; idle(4); wr(4'hC, 32'h0FFF_FFFF);

    // R4: level-high re-arms while held; clear sticks after release
    tag = "R4";
    wr(4'h0, {8{TRIG_HIGH}}); wr(4'h4, {8{TRIG_HIGH}});
    lineIn[9] = 1'b1; idle(3);
    wr(4'hC, 32'h200); wr(4'hC, 32'h200); idle(1);
    lineIn[9] = 1'b0; idle(3);
    wr(4'hC, 32'h200); idle(2);
    wr(4'h0, {8{TRIG_LOW}}); idle(3);
    wr(4'hC, 32'h0FFF_FFFF); idle(2);

    // R8: masked line still becomes pending, unmask exposes it
    tag = "R8";
    wr(4'h0, {8{TRIG_RISE}}); wr(4'h4, {8{TRIG_RISE}});
    wr(4'hC, 32'h0FFF_FFFF); wr(4'h8, 32'h20); idle(2);
    pulse(5, 3); idle(2);
    wr(4'h8, 32'h0); idle(2);
    wr(4'hC, 32'h20); idle(1);

    // R7: zero write keeps bits; clear colliding with detection loses
    tag = "R7";
    pulse(14, 3);
    wr(4'hC, 32'h0); idle(1);
    wr(4'hC, 32'h4000); idle(1);
    lineIn[25] = 1'b1; step(); step();
    wr(4'hC, 32'h0200_0000);
    idle(2);
    lineIn[25] = 1'b0;
    wr(4'hC, 32'h0200_0000); idle(2);

    // R10: non-standard codes decode bitwise, bit 3 ignored
    tag = "R10";
    wr(4'h0, 32'hBBBB_BBBB); wr(4'h4, 32'h0099_9999);
    wr(4'hC, 32'h0FFF_FFFF); idle(2);
    pulse(1, 4); pulse(18, 4);
    wr(4'hC, 32'h0FFF_FFFF); idle(2);

    // R9: random activity, writes and collisions
    tag = "R9";
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 20) lineIn[$urandom_range(0, 27)] ^= 1'b1;
      if (r >= 90) begin
        logic [3:0] a;
        case ($urandom_range(0, 4))
          0: a = 4'h0; 1: a = 4'h4; 2: a = 4'h8; 3: a = 4'hC; default: a = 4'h6;
        endcase
        wr(a, (a == 4'h8) ? ($urandom() & 32'h0F0F_0F0F) : $urandom());
      end else begin
        busAddr = (r < 60) ? 4'hC : 4'h8;
        step();
      end
    end
    busAddr = 4'hC; idle(2);

    finished = 1'b1;
    finish();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired in %s", tag);
      finish();
    end
  end

endmodule